// File: doc/BRIEF.md
# Dual Interval Timer with Interrupt Flags

This block is a byte-wide register peripheral holding two 16-bit down-counters. Both counters step on a one-cycle tick-enable input, so the block runs from any timebase the chip provides. Timer 1 runs freely. It reloads from its own latch every time its count has passed through zero. Timer 2 is a one-shot. Software loads it, it counts down, and it keeps counting past zero without reloading.

A 7-bit flag register records timer events. A 7-bit enable register selects which flags drive the interrupt line. Some register accesses have side effects: a counter load, a flag clear, or both. Software can therefore arm a timer and acknowledge its interrupt without a separate command register. The bus is a simple strobe (`bus_sel`, `bus_wr`). Writes take effect at the clock edge. Read data is combinational in the default variant.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset, the counters and latches hold these values:
  - Timer 1 latch and count read 0xFFFF.
  - Timer 2 count reads 0xFFFF.
  - Timer 2 low latch is 0.
  - Flags and enables are 0, so offset 13 reads 0x00, offset 14 reads 0x80 and `irq` is low.
- R2: Timer 1 counts one step per tick from its latch value down through 0 to 0xFFFF. On the next tick it reloads the latch value, so one period is latch+2 ticks.
- R3: Timer 1 sets flag bit 6 on the tick that brings its count to 0. A reload to 0 counts as reaching 0. A bus load does not.
- R4: A write to offset 4 or offset 6 replaces only the low byte of the timer 1 latch. The count is untouched. The new latch is used at the next reload.
- R5: A write to offset 5 replaces the latch high byte, copies the whole latch into the count and clears flag bit 6.
- R6: A write to offset 7 replaces the latch high byte and clears flag bit 6, without changing the count.
- R7: Reads return these bytes:
  - Offsets 4 and 5 return the low and high byte of the live timer 1 count.
  - Offsets 6 and 7 return the timer 1 latch bytes.
  - Offsets 8 and 9 return the timer 2 count bytes.
- R8: A write to offset 8 stores a byte without touching the timer 2 count. A write to offset 9 loads the count with {written byte, stored byte} and arms the one-shot.
- R9: Timer 2 decrements one step per tick and wraps from 0 to 0xFFFF. It sets flag bit 5 only on the first arrival at 0 after a load.
- R10: Reading offset 8 clears flag bit 5. Reading offset 9 does not.
- R11: `irq` is high exactly when some flag bit and its enable bit are both 1. The flag and enable registers behave as follows:
  - Writing offset 14 with bit 7 = 1 sets the enables given in bits 6..0.
  - Writing offset 14 with bit 7 = 0 clears the enables given in bits 6..0.
  - Reading offset 14 returns 1 in bit 7.
  - Reading offset 13 returns `irq` in bit 7.
  - Writing 1s to offset 13 clears those flags.
- R12: When the tick input is low and no load happens, neither count changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle count enable for both timers |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte register offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data |
| irq | output | 1 | Interrupt request |

## Verification
Some rules are checked on every cycle by assertions:
- Timer 1 reloads its latch after the count has passed 0xFFFF.
- Timer 1 reads 0 after a zero event.
- Bus loads put the expected value into both counters.
- Timer 2 disarms after its first zero event.
- The prioritised clear wins over a concurrent set.
- Counters hold when there is no tick.

The bench scenarios cover what needs whole sequences:
- The latch+2 period measured between two flag events.
- The latch-low-byte write being used only at the next reload.
- The read side effects on the flags.
- The set and clear encoding of the enable register.
- The absence of a second timer 2 flag after a full 65534-tick wraparound.

// File: rtl/dit_pkg.sv
package dit_pkg;
   // Register offsets; software decodes these, so the values are fixed.
   localparam logic [3:0] OFF_T1_LO  = 4'd4;
   localparam logic [3:0] OFF_T1_HI  = 4'd5;
   localparam logic [3:0] OFF_L1_LO  = 4'd6;
   localparam logic [3:0] OFF_L1_HI  = 4'd7;
   localparam logic [3:0] OFF_T2_LO  = 4'd8;
   localparam logic [3:0] OFF_T2_HI  = 4'd9;
   localparam logic [3:0] OFF_FLAGS  = 4'd13;
   localparam logic [3:0] OFF_ENABLE = 4'd14;

   // Flag bit positions inside the flag and enable registers.
   localparam int unsigned FLAG_T1 = 6;
   localparam int unsigned FLAG_T2 = 5;
endpackage

// File: rtl/dit_timer1.sv
module dit_timer1 #(
   parameter int unsigned DATA_W = 8,
   localparam int unsigned CNT_W = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_lat_lo,   // latch low byte only
   input  logic              wr_load,     // latch high byte + load count
   input  logic              wr_lat_hi,   // latch high byte only
   input  logic [DATA_W-1:0] wdata,
   output logic [CNT_W-1:0]  cnt,
   output logic [CNT_W-1:0]  latch,
   output logic              zero_evt
);
   logic [CNT_W-1:0] cnt_q, lat_q, cnt_nxt;
   logic             under_q;   // count has passed from 0 to all-ones

   always_comb begin
      if (under_q) cnt_nxt = lat_q;
      else         cnt_nxt = cnt_q - 1'b1;
   end

   assign zero_evt = tick && !wr_load && (cnt_nxt == '0);
   assign cnt      = cnt_q;
   assign latch    = lat_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '1;
         lat_q   <= '1;
         under_q <= 1'b0;
      end else begin
         if (wr_lat_lo)
            lat_q[DATA_W-1:0] <= wdata;
         if (wr_lat_hi || wr_load)
            lat_q[CNT_W-1:DATA_W] <= wdata;
         if (wr_load) begin
            cnt_q   <= {wdata, lat_q[DATA_W-1:0]};
            under_q <= 1'b0;
         end else if (tick) begin
            cnt_q   <= cnt_nxt;
            under_q <= !under_q && (cnt_q == '0);
         end
      end
   end

   p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && under_q && !wr_load) |=> cnt_q == $past(lat_q));
   p_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      zero_evt |=> cnt_q == '0);
   p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_load |=> cnt_q == {$past(wdata), $past(lat_q[DATA_W-1:0])});
   p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !wr_load) |=> $stable(cnt_q));
endmodule

// File: rtl/dit_timer2.sv
module dit_timer2 #(
   parameter int unsigned DATA_W = 8,
   localparam int unsigned CNT_W = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [DATA_W-1:0] wdata,
   output logic [CNT_W-1:0]  cnt,
   output logic              zero_evt
);
   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W-1:0] lo_q;
   logic              armed_q;

   assign zero_evt = tick && !wr_hi && armed_q && (cnt_q == CNT_W'(1));
   assign cnt      = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '1;
         lo_q    <= '0;
         armed_q <= 1'b0;
      end else begin
         if (wr_lo) lo_q <= wdata;
         if (wr_hi) begin
            cnt_q   <= {wdata, lo_q};
            armed_q <= 1'b1;
         end else if (tick) begin
            cnt_q <= cnt_q - 1'b1;
            if (zero_evt) armed_q <= 1'b0;
         end
      end
   end

   p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hi |=> cnt_q == {$past(wdata), $past(lo_q)});
   p_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
      zero_evt |=> !armed_q);
   p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !wr_hi) |=> $stable(cnt_q));
endmodule

// File: rtl/dit_irq_ctrl.sv
module dit_irq_ctrl #(
   parameter int unsigned DATA_W = 8,
   localparam int unsigned FLAG_W = DATA_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FLAG_W-1:0] set_v,     // hardware events
   input  logic [FLAG_W-1:0] hi_clr_v,  // clears that beat a set
   input  logic [FLAG_W-1:0] lo_clr_v,  // clears that lose to a set
   input  logic              wr_enable,
   input  logic [DATA_W-1:0] wdata,
   output logic [FLAG_W-1:0] flags,
   output logic [FLAG_W-1:0] enables,
   output logic              irq
);
   logic [FLAG_W-1:0] flags_q, en_q;

   for (genvar b = 0; b < FLAG_W; b++) begin : g_flag
      always_ff @(posedge clk) begin
         if (!rst_n)           flags_q[b] <= 1'b0;
         else if (hi_clr_v[b]) flags_q[b] <= 1'b0;
         else if (set_v[b])    flags_q[b] <= 1'b1;
         else if (lo_clr_v[b]) flags_q[b] <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) en_q <= '0;
      else if (wr_enable) begin
         if (wdata[DATA_W-1]) en_q <= en_q | wdata[FLAG_W-1:0];
         else                 en_q <= en_q & ~wdata[FLAG_W-1:0];
      end
   end

   assign flags   = flags_q;
   assign enables = en_q;
   assign irq     = |(flags_q & en_q);

   p_hiclr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_clr_v != '0) |=> ($past(hi_clr_v) & flags_q) == '0);
   p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (set_v != '0) |=> (($past(set_v) & ~$past(hi_clr_v)) & ~flags_q) == '0);
   p_loclr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_clr_v != '0) |=> ($past(lo_clr_v) & ~$past(set_v) & flags_q) == '0);
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
   import dit_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 4,
   parameter bit          RD_REG = 1'b0,  // 1: registered read data
   localparam int unsigned CNT_W  = 2 * DATA_W,
   localparam int unsigned FLAG_W = DATA_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   if (DATA_W < 8) begin : g_bad_data_w
      $error("DATA_W must be at least 8 to hold the flag positions");
   end
   if (ADDR_W < 4) begin : g_bad_addr_w
      $error("ADDR_W must be at least 4 to reach every offset");
   end

   logic acc_wr, acc_rd;
   assign acc_wr = bus_sel && bus_wr;
   assign acc_rd = bus_sel && !bus_wr;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [3:0] off);
      return a == ADDR_W'(off);
   endfunction

   logic [CNT_W-1:0]  t1_cnt, t1_lat, t2_cnt;
   logic              t1_zero, t2_zero;
   logic [FLAG_W-1:0] flags, enables, set_v, hi_clr_v, lo_clr_v;

   dit_timer1 #(.DATA_W(DATA_W)) u_t1 (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick_en),
      .wr_lat_lo (acc_wr && (hit(bus_addr, OFF_T1_LO) || hit(bus_addr, OFF_L1_LO))),
      .wr_load   (acc_wr && hit(bus_addr, OFF_T1_HI)),
      .wr_lat_hi (acc_wr && hit(bus_addr, OFF_L1_HI)),
      .wdata     (bus_wdata),
      .cnt       (t1_cnt),
      .latch     (t1_lat),
      .zero_evt  (t1_zero)
   );

   dit_timer2 #(.DATA_W(DATA_W)) u_t2 (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick_en),
      .wr_lo    (acc_wr && hit(bus_addr, OFF_T2_LO)),
      .wr_hi    (acc_wr && hit(bus_addr, OFF_T2_HI)),
      .wdata    (bus_wdata),
      .cnt      (t2_cnt),
      .zero_evt (t2_zero)
   );

   always_comb begin
      set_v    = '0;
      hi_clr_v = '0;
      lo_clr_v = '0;
      set_v[FLAG_T1]    = t1_zero;
      set_v[FLAG_T2]    = t2_zero;
      hi_clr_v[FLAG_T1] = acc_wr && (hit(bus_addr, OFF_T1_HI) || hit(bus_addr, OFF_L1_HI));
      if (acc_wr && hit(bus_addr, OFF_FLAGS))
         lo_clr_v = bus_wdata[FLAG_W-1:0];
      if (acc_rd && hit(bus_addr, OFF_T2_LO))
         lo_clr_v[FLAG_T2] = 1'b1;
   end

   dit_irq_ctrl #(.DATA_W(DATA_W)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_v     (set_v),
      .hi_clr_v  (hi_clr_v),
      .lo_clr_v  (lo_clr_v),
      .wr_enable (acc_wr && hit(bus_addr, OFF_ENABLE)),
      .wdata     (bus_wdata),
      .flags     (flags),
      .enables   (enables),
      .irq       (irq)
   );

   logic [DATA_W-1:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      if      (hit(bus_addr, OFF_T1_LO))  rd_mux = t1_cnt[DATA_W-1:0];
      else if (hit(bus_addr, OFF_T1_HI))  rd_mux = t1_cnt[CNT_W-1:DATA_W];
      else if (hit(bus_addr, OFF_L1_LO))  rd_mux = t1_lat[DATA_W-1:0];
      else if (hit(bus_addr, OFF_L1_HI))  rd_mux = t1_lat[CNT_W-1:DATA_W];
      else if (hit(bus_addr, OFF_T2_LO))  rd_mux = t2_cnt[DATA_W-1:0];
      else if (hit(bus_addr, OFF_T2_HI))  rd_mux = t2_cnt[CNT_W-1:DATA_W];
      else if (hit(bus_addr, OFF_FLAGS))  rd_mux = {irq, flags};
      else if (hit(bus_addr, OFF_ENABLE)) rd_mux = {1'b1, enables};
   end

   if (RD_REG) begin : g_rd_reg
      logic [DATA_W-1:0] rd_q;
      always_ff @(posedge clk) begin
         if (!rst_n)      rd_q <= '0;
         else if (acc_rd) rd_q <= rd_mux;
      end
      assign bus_rdata = rd_q;
   end else begin : g_rd_comb
      assign bus_rdata = acc_rd ? rd_mux : '0;
   end

   p_irq_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (flags & enables) != '0);
endmodule

// File: tb/dual_interval_timer_tb.sv
module dual_interval_timer_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic       bus_sel = 1'b0;
   logic       bus_wr = 1'b0;
   logic [3:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       irq;

   always #2.5 clk = ~clk;   // 200 MHz

   dual_interval_timer u_dut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq(irq)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // Scoreboard: expected read bytes, masks and requirement tags.
   logic [7:0] q_exp[$];
   logic [7:0] q_mask[$];
   string      q_tag[$];

   always begin
      @(negedge clk);
      #2;
      if (bus_sel && !bus_wr) begin
         logic [7:0] e, m;
         string t;
         e = q_exp.pop_front();
         m = q_mask.pop_front();
         t = q_tag.pop_front();
         checks++;
         if ((bus_rdata & m) !== (e & m)) begin
            errors++;
            $display("FAIL %s: addr %0d read %02h expected %02h (mask %02h)",
                     t, bus_addr, bus_rdata, e, m);
         end
      end
   end

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, input logic [7:0] e,
                     input logic [7:0] m, input string t);
      q_exp.push_back(e); q_mask.push_back(m); q_tag.push_back(t);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic ticks(input int n);
      @(negedge clk);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
   endtask

   task automatic chk_irq(input logic e, input string t);
      @(negedge clk);
      #1;
      checks++;
      if (irq !== e) begin
         errors++;
         $display("FAIL %s: irq=%0b expected %0b", t, irq, e);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(4, 8'hFF, 8'hFF, "R1"); rd(5, 8'hFF, 8'hFF, "R1");
      rd(6, 8'hFF, 8'hFF, "R1"); rd(7, 8'hFF, 8'hFF, "R1");
      rd(8, 8'hFF, 8'hFF, "R1"); rd(9, 8'hFF, 8'hFF, "R1");
      rd(13, 8'h00, 8'hFF, "R1"); rd(14, 8'h80, 8'hFF, "R1");
      chk_irq(1'b0, "R1");

      // R5 load timer 1 with 5; R7 readback
      wr(6, 8'h05); wr(5, 8'h00);
      rd(4, 8'h05, 8'hFF, "R5"); rd(5, 8'h00, 8'hFF, "R7");
      rd(7, 8'h00, 8'hFF, "R7");

      // R3 flag only when the count reaches 0
      ticks(4); rd(13, 8'h00, 8'hFF, "R3");
      ticks(1); rd(4, 8'h00, 8'hFF, "R2"); rd(13, 8'h40, 8'hFF, "R3");

      // R2 passes through 0xFFFF, then reloads
      ticks(1); rd(4, 8'hFF, 8'hFF, "R2"); rd(5, 8'hFF, 8'hFF, "R2");
      ticks(1); rd(4, 8'h05, 8'hFF, "R2");

      // R11 write-one-to-clear; R2 period latch+2 between flag events
      wr(13, 8'h40); rd(13, 8'h00, 8'hFF, "R11");
      ticks(5); rd(13, 8'h40, 8'hFF, "R2");

      // R11 enable set encoding and irq
      wr(14, 8'hC0); chk_irq(1'b1, "R11");
      rd(14, 8'hC0, 8'hFF, "R11"); rd(13, 8'hC0, 8'hFF, "R11");

      // R6 clears flag, count untouched
      wr(7, 8'h00); rd(4, 8'h00, 8'hFF, "R6"); chk_irq(1'b0, "R6");
      rd(13, 8'h00, 8'hFF, "R6");

      // R4 latch low write used only at next reload
      wr(4, 8'h33); rd(6, 8'h33, 8'hFF, "R4"); rd(4, 8'h00, 8'hFF, "R4");
      ticks(2); rd(4, 8'h33, 8'hFF, "R4"); rd(5, 8'h00, 8'hFF, "R4");
      rd(13, 8'h00, 8'hFF, "R3");

      // R12 no tick, no change
      repeat (10) @(negedge clk);
      rd(4, 8'h33, 8'hFF, "R12");

      // R5 load 0x1033
      wr(5, 8'h10); rd(4, 8'h33, 8'hFF, "R5"); rd(5, 8'h10, 8'hFF, "R5");

      // R8 timer 2 staging and load
      wr(8, 8'h03); rd(9, 8'hFF, 8'hFF, "R8");
      wr(9, 8'h00); rd(8, 8'h03, 8'hFF, "R8"); rd(9, 8'h00, 8'hFF, "R8");

      // R9 flag at zero; R11 irq through bit 5 enable
      ticks(3); rd(13, 8'h20, 8'h20, "R9");
      wr(14, 8'hA0); chk_irq(1'b1, "R11");
      rd(9, 8'h00, 8'hFF, "R10"); rd(13, 8'h20, 8'h20, "R10");
      ticks(2); rd(8, 8'hFE, 8'hFF, "R9");
      rd(13, 8'h00, 8'h20, "R10"); chk_irq(1'b0, "R10");

      // R9 wrap: no second flag on the next arrival at 0
      wr(14, 8'h40);
      ticks(65534);
      rd(13, 8'h00, 8'h20, "R9"); chk_irq(1'b0, "R9");
      rd(8, 8'h00, 8'hFF, "R9"); rd(9, 8'h00, 8'hFF, "R9");

      // R8 reload re-arms the one-shot
      wr(8, 8'h02); wr(9, 8'h00); ticks(2);
      rd(13, 8'h20, 8'h20, "R8"); chk_irq(1'b1, "R8");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule